// File: doc/BRIEF.md
# Multi-Bank Warp Scratchpad

This block is an on-chip scratchpad that takes one memory request per warp. Each request has 32 lanes. A lane carries an active flag, a word address, a read/write flag, 32 bits of write data and four byte enables. The storage is divided into independent banks, and each bank can perform one 32-bit word access per cycle. The bank that holds a word is chosen by the low bits of its word address. The remaining bits select the row inside that bank.

Lanes that target distinct banks are all served in the same cycle. Lanes that target the same word are merged into a single access. When lanes target different words inside one bank, the block replays the request over extra cycles. In each replay cycle, every bank serves its lowest-numbered pending lane together with every other lane that shares that lane's word. The block returns the results of all lanes together once the whole warp has been served. Both the request side and the response side use a valid/ready handshake, and only one warp can be in flight at a time.

Top module: `smem_scratch`

## Requirements
- R1: A word address maps to bank `addr[4:0]` and to row `addr[8:5]` inside that bank (32 banks of 16 rows at the default size), so each of the 512 word addresses names its own storage word.
- R2: When all active lanes address distinct banks, the request completes in one cycle. The cycle count is measured from the accepting clock edge to the edge after which the response valid signal is high.
- R3: The cycle count of a request equals the largest number of distinct words addressed in any one bank among its active lanes, with a minimum of one.
- R4: Lanes that address the same word do not conflict: a warp whose lanes all address one word completes in one cycle.
- R5: Every active lane, whether it reads or writes, returns the contents of its word as they stood before the request, even when other lanes of the same request write that word.
- R6: When several lanes of one request write the same word, for each byte the highest-numbered lane that enables that byte sets the byte's value.
- R7: Byte enable bit k (lane enable field bits [4l+3:4l]) controls data byte k (bits [8k+7:8k]); bytes whose enable is clear keep their previous contents.
- R8: Inactive lanes make no bank access and return zero read data. A request with no active lane completes in one cycle.
- R9: The request ready signal is low from the accepting edge until the response has been taken. The response valid signal and the response data stay unchanged while the response ready signal is low.
- R10: Data written by a request is returned by reads in later requests.
- R11: After reset, the request ready signal is high and the response valid signal is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A warp request is offered |
| req_ready | output | 1 | The block can accept a request |
| req_active | input | 32 | Per-lane active flag |
| req_write | input | 32 | Per-lane write flag (1 = write) |
| req_addr | input | 288 | Per-lane 9-bit word address, lane l at bits [9l+8:9l] |
| req_wdata | input | 1024 | Per-lane write data, lane l at bits [32l+31:32l] |
| req_be | input | 128 | Per-lane byte enables, lane l at bits [4l+3:4l] |
| resp_valid | output | 1 | Results for the whole warp are available |
| resp_ready | input | 1 | The consumer takes the response |
| resp_rdata | output | 1024 | Per-lane prior word contents, zero for inactive lanes |

## Verification
The assertions assume that request fields are sampled only on the accepting edge. They also assume that the consumer may hold the response ready signal low for any number of cycles. The bench therefore changes request fields only at falling edges while the request is not being accepted, and it stretches one response for several cycles with ready held low. The assertions also take for granted that word addresses fall inside the configured storage. The bench keeps every generated address within the 512-word range by masking it. The bench sweeps address strides from 1 to 33, which covers conflict degrees from one to sixteen. It also sweeps broadcast addresses, byte-enable patterns, overlapping writers and lane-activity masks, and it computes the expected cycle counts and data from a word-level model.

// File: rtl/smem_pkg.sv
package smem_pkg;
    // Request sequencing state of the scratchpad.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_DONE = 2'd2
    } smem_state_t;
endpackage

// File: rtl/smem_pick.sv
// Per-bank lane picker.
// Among the pending lanes that map to bank BANK, it selects the lowest-numbered one.
// It also selects every pending lane that addresses the same word, and it merges
// their writes so that the highest lane wins for each enabled byte.
// Assumes BANKS is a power of two, so the bank index is the low BB address bits.
module smem_pick #(
    parameter int LANES = 32,
    parameter int BB    = 5,
    parameter int RW    = 4,
    parameter int BANK  = 0
) (
    input  logic [LANES-1:0]      pending,
    input  logic [LANES*(BB+RW)-1:0] addr,
    input  logic [LANES-1:0]      write,
    input  logic [LANES*32-1:0]   wdata,
    input  logic [LANES*4-1:0]    be,
    output logic [LANES-1:0]      sel,
    output logic [RW-1:0]         row,
    output logic                  we,
    output logic [31:0]           wword,
    output logic [3:0]            wbe
);
    localparam int AW = BB + RW;
    localparam logic [BB-1:0] MY_BANK = BANK[BB-1:0];

    logic          found;
    logic [AW-1:0] pick_addr;

    // Find the lowest pending lane in this bank and take its word address.
    always_comb begin
        found     = 1'b0;
        pick_addr = '0;
        for (int l = 0; l < LANES; l++) begin
            if (!found && pending[l] && addr[l*AW +: BB] == MY_BANK) begin
                found     = 1'b1;
                pick_addr = addr[l*AW +: AW];
            end
        end
    end

    // Gather every lane that shares the picked word and merge its byte writes.
    always_comb begin
        sel   = '0;
        wword = '0;
        wbe   = '0;
        for (int l = 0; l < LANES; l++) begin
            if (found && pending[l] && addr[l*AW +: AW] == pick_addr) begin
                sel[l] = 1'b1;
                if (write[l]) begin
                    for (int k = 0; k < 4; k++) begin
                        if (be[l*4 + k]) begin
                            wword[k*8 +: 8] = wdata[l*32 + k*8 +: 8];
                            wbe[k]          = 1'b1;
                        end
                    end
                end
            end
        end
    end

    assign row = pick_addr[AW-1:BB];
    assign we  = |wbe;
endmodule

// File: rtl/smem_bank.sv
// One bank of storage: ROWS words of 32 bits with byte-granular writes.
// Reads are combinational and return the contents from before this edge's write.
// The contents are not reset; software must write a word before reading it.
module smem_bank #(
    parameter int ROWS = 16,
    parameter int RW   = 4
) (
    input  logic          clk,
    input  logic          we,
    input  logic [RW-1:0] row,
    input  logic [31:0]   wword,
    input  logic [3:0]    wbe,
    output logic [31:0]   rword
);
    logic [31:0] mem [ROWS];

    // Apply the merged byte writes at the clock edge.
    always_ff @(posedge clk) begin
        if (we) begin
            for (int k = 0; k < 4; k++) begin
                if (wbe[k]) mem[row][k*8 +: 8] <= wword[k*8 +: 8];
            end
        end
    end

    assign rword = mem[row];
endmodule

// File: rtl/smem_scratch.sv
// Banked warp scratchpad top.
// It accepts one warp request, replays it until every active lane has been served,
// and then holds the per-lane results until the consumer takes them.
// Assumes BANKS and ROWS are powers of two; the word address is {row, bank}.
module smem_scratch #(
    parameter int LANES = 32,
    parameter int BANKS = 32,
    parameter int ROWS  = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [LANES-1:0]      req_active,
    input  logic [LANES-1:0]      req_write,
    input  logic [LANES*($clog2(BANKS)+$clog2(ROWS))-1:0] req_addr,
    input  logic [LANES*32-1:0]   req_wdata,
    input  logic [LANES*4-1:0]    req_be,
    output logic                  resp_valid,
    input  logic                  resp_ready,
    output logic [LANES*32-1:0]   resp_rdata
);
    import smem_pkg::*;

    localparam int BB = $clog2(BANKS);
    localparam int RW = $clog2(ROWS);
    localparam int AW = BB + RW;
    localparam int CW = $clog2(LANES + 2) + 1;

    smem_state_t          state;
    logic [LANES-1:0]     act_q, pend_q, wr_q;
    logic [LANES*AW-1:0]  addr_q;
    logic [LANES*32-1:0]  wd_q, rd_q;
    logic [LANES*4-1:0]   be_q;
    logic [CW-1:0]        busy_cnt;

    logic [LANES-1:0]     sel_b  [BANKS];
    logic [31:0]          rword_b[BANKS];
    logic [LANES-1:0]     served;
    logic [31:0]          lane_rd[LANES];
    logic                 accept;

    assign req_ready  = (state == ST_IDLE);
    assign resp_valid = (state == ST_DONE);
    assign resp_rdata = rd_q;
    assign accept     = req_valid && req_ready;

    // One picker and one storage bank per bank index.
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic [RW-1:0] row;
        logic          we;
        logic [31:0]   wword;
        logic [3:0]    wbe;

        smem_pick #(.LANES(LANES), .BB(BB), .RW(RW), .BANK(b)) u_pick (
            .pending(pend_q), .addr(addr_q), .write(wr_q), .wdata(wd_q), .be(be_q),
            .sel(sel_b[b]), .row(row), .we(we), .wword(wword), .wbe(wbe)
        );

        smem_bank #(.ROWS(ROWS), .RW(RW)) u_bank (
            .clk(clk), .we(we), .row(row), .wword(wword), .wbe(wbe), .rword(rword_b[b])
        );
    end

    // Combine the per-bank selections into the set of lanes served this cycle.
    always_comb begin
        served = '0;
        for (int b = 0; b < BANKS; b++) served = served | sel_b[b];
    end

    // Route each lane's bank read word back to the lane.
    always_comb begin
        for (int l = 0; l < LANES; l++) lane_rd[l] = rword_b[addr_q[l*AW +: BB]];
    end

    // Sequence the request: capture, replay until drained, then hold the response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            act_q    <= '0;
            pend_q   <= '0;
            wr_q     <= '0;
            addr_q   <= '0;
            wd_q     <= '0;
            be_q     <= '0;
            rd_q     <= '0;
            busy_cnt <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        state    <= ST_BUSY;
                        act_q    <= req_active;
                        pend_q   <= req_active;
                        wr_q     <= req_write;
                        addr_q   <= req_addr;
                        wd_q     <= req_wdata;
                        be_q     <= req_be;
                        rd_q     <= '0;
                        busy_cnt <= '0;
                    end
                end
                ST_BUSY: begin
                    busy_cnt <= busy_cnt + 1'b1;
                    for (int l = 0; l < LANES; l++) begin
                        if (served[l]) rd_q[l*32 +: 32] <= lane_rd[l];
                    end
                    pend_q <= pend_q & ~served;
                    if ((pend_q & ~served) == '0) state <= ST_DONE;
                end
                ST_DONE: begin
                    if (resp_ready) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Flag any inactive lane whose returned data is not zero.
    logic inact_nonzero;
    always_comb begin
        inact_nonzero = 1'b0;
        for (int l = 0; l < LANES; l++) begin
            if (!act_q[l] && rd_q[l*32 +: 32] != '0) inact_nonzero = 1'b1;
        end
    end

    // R3: replay length never exceeds one cycle per lane.
    assert_busy_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy_cnt <= CW'(LANES));
    // R3: every replay cycle with lanes pending makes progress.
    assert_progress_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUSY && pend_q != '0) |-> served != '0);
    // R8: only pending (active, unserved) lanes are ever served.
    assert_served_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (served & ~pend_q) == '0);
    // R8: inactive lanes return zero.
    assert_inactive_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> !inact_nonzero);
    // R9: no second request is accepted right after one is taken.
    assert_ready_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready);
    // R9: a stalled response keeps its valid and data.
    assert_resp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_rdata)));
endmodule

// File: tb/tb_smem_scratch.sv
// Bench for smem_scratch at its default size (32 lanes, 32 banks, 16 rows).
module tb_smem_scratch;
    localparam int CLK_P = 10;
    localparam int L     = 32;
    localparam int AW    = 9;
    localparam int WORDS = 512;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [L-1:0]      req_active = '0;
    logic [L-1:0]      req_write = '0;
    logic [L*AW-1:0]   req_addr = '0;
    logic [L*32-1:0]   req_wdata = '0;
    logic [L*4-1:0]    req_be = '0;
    logic              resp_valid;
    logic              resp_ready = 1'b0;
    logic [L*32-1:0]   resp_rdata;

    int total = 0;
    int bad   = 0;

    logic [31:0] model [WORDS];
    logic        t_act [L];
    logic        t_wr  [L];
    int          t_adr [L];
    logic [31:0] t_wd  [L];
    logic [3:0]  t_be  [L];

    smem_scratch dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_active(req_active), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_be(req_be), .resp_valid(resp_valid),
        .resp_ready(resp_ready), .resp_rdata(resp_rdata)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] hash(input int a, input int salt);
        return (32'(a) * 32'h9E37_79B1) ^ 32'(salt);
    endfunction

    task automatic clear_lanes();
        for (int l = 0; l < L; l++) begin
            t_act[l] = 1'b0; t_wr[l] = 1'b0; t_adr[l] = 0;
            t_wd[l] = '0; t_be[l] = '0;
        end
    endtask

    // Issue the staged request and check cycle count and per-lane data against the model.
    task automatic run_req(input string ltag, input string dtag, input int hold);
        logic [31:0] exp_rd [L];
        int          per_bank [32];
        int          exp_lat;
        int          cnt;
        int          mism;
        int          first_l;
        for (int b = 0; b < 32; b++) per_bank[b] = 0;
        for (int l = 0; l < L; l++) begin
            exp_rd[l] = t_act[l] ? model[t_adr[l]] : 32'h0;
            if (t_act[l]) begin
                bit dup = 1'b0;
                for (int m = 0; m < l; m++)
                    if (t_act[m] && t_adr[m] == t_adr[l]) dup = 1'b1;
                if (!dup) per_bank[t_adr[l] % 32]++;
            end
        end
        exp_lat = 1;
        for (int b = 0; b < 32; b++) if (per_bank[b] > exp_lat) exp_lat = per_bank[b];

        @(negedge clk);
        for (int l = 0; l < L; l++) begin
            req_active[l]           = t_act[l];
            req_write[l]            = t_wr[l];
            req_addr[l*AW +: AW]    = AW'(t_adr[l]);
            req_wdata[l*32 +: 32]   = t_wd[l];
            req_be[l*4 +: 4]        = t_be[l];
        end
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        cnt = 0;
        while (!resp_valid && cnt < 100) begin
            @(negedge clk);
            cnt++;
        end
        chk(cnt == exp_lat, ltag, "cycle count", cnt, exp_lat);

        mism = 0; first_l = 0;
        for (int l = L-1; l >= 0; l--) begin
            if (resp_rdata[l*32 +: 32] !== exp_rd[l]) begin mism++; first_l = l; end
        end
        chk(mism == 0, dtag, $sformatf("lane %0d read data", first_l),
            resp_rdata[first_l*32 +: 32], exp_rd[first_l]);

        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            chk(resp_valid && !req_ready &&
                resp_rdata[first_l*32 +: 32] === exp_rd[first_l],
                "R9", "stalled response held", {resp_valid, req_ready}, 2'b10);
        end
        resp_ready = 1'b1;
        @(negedge clk);
        resp_ready = 1'b0;
        if (hold > 0)
            chk(req_ready && !resp_valid, "R9", "ready after response taken",
                {req_ready, resp_valid}, 2'b10);

        for (int l = 0; l < L; l++) begin
            if (t_act[l] && t_wr[l]) begin
                for (int k = 0; k < 4; k++)
                    if (t_be[l][k]) model[t_adr[l]][k*8 +: 8] = t_wd[l][k*8 +: 8];
            end
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=expired expected=done");
        summary();
        $finish;
    end

    initial begin
        for (int a = 0; a < WORDS; a++) model[a] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready === 1'b1 && resp_valid === 1'b0, "R11", "reset handshake",
            {req_ready, resp_valid}, 2'b10);

        // R1 R2 R10: fill every word with stride-1 full-warp writes (one cycle each).
        for (int r = 0; r < 16; r++) begin
            clear_lanes();
            for (int l = 0; l < L; l++) begin
                t_act[l] = 1'b1; t_wr[l] = 1'b1; t_adr[l] = r*32 + l;
                t_wd[l] = hash(r*32 + l, 32'h5A); t_be[l] = 4'hF;
            end
            run_req("R2", "R5", 0);
        end

        // R3 R1 R10: strided reads sweep the conflict degree from 1 up to 16.
        for (int s = 1; s <= 33; s++) begin
            clear_lanes();
            for (int l = 0; l < L; l++) begin
                t_act[l] = 1'b1; t_adr[l] = (l*s + s) % WORDS;
            end
            run_req("R3", "R10", 0);
        end

        // R4: every lane reads one word, for several words.
        for (int w = 0; w < 4; w++) begin
            clear_lanes();
            for (int l = 0; l < L; l++) begin t_act[l] = 1'b1; t_adr[l] = 77 + 101*w; end
            run_req("R4", "R10", 0);
        end

        // R7: partial byte-enable writes, then read back.
        clear_lanes();
        for (int l = 0; l < L; l++) begin
            t_act[l] = 1'b1; t_wr[l] = 1'b1; t_adr[l] = 64 + l;
            t_wd[l] = 32'hC0DE_0000 + 32'(l); t_be[l] = 4'(l % 16);
        end
        run_req("R2", "R5", 0);
        clear_lanes();
        for (int l = 0; l < L; l++) begin t_act[l] = 1'b1; t_adr[l] = 64 + l; end
        run_req("R2", "R7", 0);

        // R6 R5: all lanes hit word 100; lanes 0 and 7 read, the rest write varying bytes.
        clear_lanes();
        for (int l = 0; l < L; l++) begin
            t_act[l] = 1'b1; t_adr[l] = 100;
            t_wr[l] = !(l == 0 || l == 7);
            t_wd[l] = {4{8'(l + 8'h30)}};
            t_be[l] = 4'(1 << (l % 4)) | ((l % 5 == 0) ? 4'h8 : 4'h0);
        end
        run_req("R4", "R5", 0);
        clear_lanes();
        for (int l = 0; l < L; l++) begin t_act[l] = 1'b1; t_adr[l] = 100; end
        run_req("R4", "R6", 0);

        // R6: conflicting writers in one bank, two words each shared by several lanes.
        clear_lanes();
        for (int l = 0; l < L; l++) begin
            t_act[l] = 1'b1; t_wr[l] = 1'b1; t_adr[l] = (l % 2) ? 3 : 35;
            t_wd[l] = hash(l, 7); t_be[l] = 4'(l % 16) | 4'h1;
        end
        run_req("R3", "R5", 0);
        clear_lanes();
        t_act[0] = 1'b1; t_adr[0] = 3; t_act[1] = 1'b1; t_adr[1] = 35;
        run_req("R3", "R6", 0);

        // R8: inactive lanes return zero under several activity masks.
        for (int p = 0; p < 4; p++) begin
            logic [31:0] mask = (p == 0) ? 32'hA5A5_A5A5 : (p == 1) ? 32'h0000_0001 :
                                (p == 2) ? 32'h8000_0000 : 32'h0F0F_F0F0;
            clear_lanes();
            for (int l = 0; l < L; l++) begin
                t_act[l] = mask[l]; t_adr[l] = (l * 32 + p) % WORDS;
                t_wr[l] = !mask[l]; t_wd[l] = 32'hFFFF_FFFF; t_be[l] = 4'hF;
            end
            run_req("R3", "R8", 0);
        end
        // R8: inactive write lanes left word 0..3 rows untouched.
        clear_lanes();
        for (int l = 0; l < L; l++) begin t_act[l] = 1'b1; t_adr[l] = l * 32 % WORDS + 1; end
        run_req("R3", "R8", 0);

        // R8: no active lane at all completes in one cycle.
        clear_lanes();
        for (int l = 0; l < L; l++) begin t_wr[l] = 1'b1; t_be[l] = 4'hF; t_adr[l] = l; end
        run_req("R8", "R8", 0);

        // R9: stall the response for five cycles.
        clear_lanes();
        for (int l = 0; l < L; l++) begin t_act[l] = 1'b1; t_adr[l] = (l * 64) % WORDS; end
        run_req("R3", "R10", 5);

        summary();
        $finish;
    end
endmodule